// File: doc/BRIEF.md
# Register List Transfer Sequencer

This block carries out the multi-register memory transfers of a small 16-bit instruction pipeline: stack push, stack pop, store-multiple and load-multiple. Each of these takes an 8-bit mask of low registers. The sequencer walks the mask and makes one word access per accepted memory handshake. It reads register values through a combinational read port and reports loaded values on a write-back port. When the whole list has been moved, it hands back the updated base or stack address.

A push can also save the link value before the listed registers. A pop can also fetch a new program counter after them, and that fetch raises a pipeline flush. The caller has already decoded the instruction. It supplies the operation code, the mask, the extra-register bit, the starting base value, the index of the base register (for load-multiple) and the current link value.

Top module: `reglist_seq`

## Requirements
- R1: After reset `mem_req`, `busy`, `done`, `base_we`, `wb_en`, `pc_we` and `flush` are all low.
- R2: A push (op 2'b00) with `extra` set first writes `lr_in` to address base-4.
- R3: A push writes the set registers of the list from index 7 down to index 0. Each write goes to an address 4 below the previous write, and the data is the value read for that register.
- R4: A pop (op 2'b01) reads the set registers from index 0 up to 7, starting at the base address and adding 4 per read. Each loaded word appears on `wb_en`/`wb_idx`/`wb_data` in the cycle its read is acknowledged.
- R5: A pop with `extra` set does one more read after the low registers. When that read is acknowledged, the word appears on `pc_data`, and `pc_we` and `flush` are raised together in the same cycle.
- R6: Store-multiple (op 2'b10) and load-multiple (op 2'b11) start at `base_in`, go upward from index 0 to 7 with 4 bytes per transfer, and ignore `extra`.
- R7: If no work is requested (empty list, and no `extra` on a push or pop), `done` is raised in the cycle after the start and no memory request is made.
- R8: Bits [1:0] of `mem_addr` are always zero. The pointer itself keeps whatever low bits `base_in` had.
- R9: `done` and `base_we` pulse for one cycle in the cycle after the last acknowledged transfer. In that cycle `base_out` is the base value after all transfers (base minus 4n for a push, plus 4n otherwise).
- R10: A `start` raised while `busy` is high is ignored.
- R11: For a load-multiple whose list contains `base_idx`, `base_we` stays low at `done`, so the loaded value is the one that remains in the base register.
- R12: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr` and `mem_we` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 2 | 00 push, 01 pop, 10 store-multiple, 11 load-multiple |
| rlist | input | 8 | Low register mask |
| extra | input | 1 | Push: save link value; pop: load program counter |
| base_idx | input | 3 | Base register index for the multiple forms |
| base_in | input | 32 | Starting base or stack address |
| lr_in | input | 32 | Link value stored by a push |
| rd_idx | output | 3 | Register read index |
| rd_data | input | 32 | Register read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| wb_en | output | 1 | Low register write-back strobe |
| wb_idx | output | 3 | Write-back register index |
| wb_data | output | 32 | Write-back data |
| pc_we | output | 1 | Program counter write strobe |
| pc_data | output | 32 | Loaded program counter value |
| flush | output | 1 | Pipeline flush request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished pulse |
| base_we | output | 1 | Base write-back strobe |
| base_out | output | 32 | Final base value |

## Verification
Two events can meet in the same clock cycle: the completion pulse of one operation and the acceptance of the next `start`. The bench issues each new operation in the cycle where the previous `done` is visible. It then checks two things: the new transfers use only the new `base_in`, and the earlier `base_out` still matched its own expected value. It also collides a second `start` with a running push. That check passes only if no extra accesses and no second `done` follow.

// File: rtl/reglist_seq.sv
module reglist_seq #(
  parameter int W    = 32,
  parameter int NREG = 8,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [NREG-1:0] rlist,
  input  logic          extra,
  input  logic [IW-1:0] base_idx,
  input  logic [W-1:0]  base_in,
  input  logic [W-1:0]  lr_in,
  output logic [IW-1:0] rd_idx,
  input  logic [W-1:0]  rd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          mem_ready,
  input  logic [W-1:0]  mem_rdata,
  output logic          wb_en,
  output logic [IW-1:0] wb_idx,
  output logic [W-1:0]  wb_data,
  output logic          pc_we,
  output logic [W-1:0]  pc_data,
  output logic          flush,
  output logic          busy,
  output logic          done,
  output logic          base_we,
  output logic [W-1:0]  base_out
);
  localparam logic [1:0] OP_PUSH = 2'b00;
  localparam logic [1:0] OP_POP  = 2'b01;
  localparam logic [1:0] OP_STM  = 2'b10;
  localparam logic [W-1:0] STEP  = W'(4);

  logic [1:0]      op_q;
  logic [NREG-1:0] mask_q, nmask, sel_bit;
  logic            xtra_q, nxtra, keep_q;
  logic [W-1:0]    ptr_q, nptr, addr_raw;
  logic [IW-1:0]   hi, lo, sel;
  logic            is_push, cur_lr, cur_pc, have_reg, ack, last, empty_in;

  always_comb begin
    hi = '0;
    lo = '0;
    for (int i = 0; i < NREG; i++)
      if (mask_q[i]) hi = IW'(i);
    for (int i = NREG-1; i >= 0; i--)
      if (mask_q[i]) lo = IW'(i);
  end

  assign is_push  = (op_q == OP_PUSH);
  assign have_reg = |mask_q;
  assign cur_lr   = is_push && xtra_q;
  assign cur_pc   = (op_q == OP_POP) && xtra_q && !have_reg;
  assign sel      = is_push ? hi : lo;
  assign sel_bit  = NREG'(1) << sel;

  assign mem_req   = busy && (have_reg || xtra_q);
  assign mem_we    = is_push || (op_q == OP_STM);
  assign addr_raw  = is_push ? ptr_q - STEP : ptr_q;
  assign mem_addr  = {addr_raw[W-1:2], 2'b00};
  assign rd_idx    = sel;
  assign mem_wdata = cur_lr ? lr_in : rd_data;
  assign ack       = mem_req && mem_ready;

  assign wb_en   = ack && !mem_we && !cur_pc;
  assign wb_idx  = sel;
  assign wb_data = mem_rdata;
  assign pc_we   = ack && cur_pc;
  assign pc_data = mem_rdata;
  assign flush   = ack && cur_pc;

  always_comb begin
    nmask = mask_q;
    nxtra = xtra_q;
    if (cur_lr || cur_pc) nxtra = 1'b0;
    else                  nmask = mask_q & ~sel_bit;
  end

  assign nptr     = is_push ? ptr_q - STEP : ptr_q + STEP;
  assign last     = ack && (nmask == '0) && !nxtra;
  assign empty_in = (rlist == '0) && !(extra && !op[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      base_we  <= 1'b0;
      base_out <= '0;
      op_q     <= OP_PUSH;
      mask_q   <= '0;
      xtra_q   <= 1'b0;
      keep_q   <= 1'b0;
      ptr_q    <= '0;
    end else begin
      done    <= 1'b0;
      base_we <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (empty_in) begin
            done     <= 1'b1;
            base_we  <= 1'b1;
            base_out <= base_in;
          end else begin
            busy   <= 1'b1;
            op_q   <= op;
            mask_q <= rlist;
            xtra_q <= extra && !op[1];
            keep_q <= (op == 2'b11) && rlist[base_idx];
            ptr_q  <= base_in;
          end
        end
      end else if (ack) begin
        mask_q <= nmask;
        xtra_q <= nxtra;
        ptr_q  <= nptr;
        if (last) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          base_we  <= !keep_q;
          base_out <= nptr;
        end
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12
  AST_LOAD_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> mem_req && mem_ready && !mem_we); // R4
  AST_PC_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |-> mem_req && mem_ready && !mem_we && flush); // R5
  AST_SINGLE_WB: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_en, pc_we})); // R5
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R7
  AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
endmodule

// File: tb/reglist_seq_tb.sv
module reglist_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, extra = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] rlist = '0;
  logic [2:0] base_idx = '0;
  logic [31:0] base_in = '0, lr_in = 32'hABCD0123;
  logic [2:0] rd_idx, wb_idx;
  logic [31:0] rd_data, mem_addr, mem_wdata, mem_rdata, wb_data, pc_data, base_out;
  logic mem_req, mem_we, mem_ready, wb_en, pc_we, flush, busy, done, base_we;

  always #4 clk = ~clk;

  logic [31:0] regs [0:7];
  logic [31:0] mem  [0:255];
  logic slow = 1'b0, rdy_tog = 1'b0;
  int cyc = 0;

  assign rd_data   = regs[rd_idx];
  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_ready = slow ? rdy_tog : 1'b1;

  reglist_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .rlist(rlist), .extra(extra),
    .base_idx(base_idx), .base_in(base_in), .lr_in(lr_in), .rd_idx(rd_idx), .rd_data(rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .pc_we(pc_we), .pc_data(pc_data), .flush(flush), .busy(busy),
    .done(done), .base_we(base_we), .base_out(base_out));

  int total = 0, bad = 0;
  logic [31:0] l_addr [0:15], l_wdata [0:15], l_wbd [0:15];
  logic l_we [0:15], l_wb [0:15], l_pc [0:15], l_fl [0:15];
  logic [2:0] l_wbi [0:15];
  int lcnt = 0, dcnt = 0, d_cyc = 0, hold_err = 0, req_idle = 0;
  logic d_bwe = 1'b0;
  logic [31:0] d_bout = '0, prev_addr = '0;
  logic prev_wait = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdy_tog <= ~rdy_tog;
  end

  always @(negedge clk) begin
    if (prev_wait && mem_addr != prev_addr) hold_err++;
    prev_wait = mem_req && !mem_ready;
    prev_addr = mem_addr;
    if (mem_req && mem_addr[1:0] != 2'b00) hold_err++;
    if (mem_req && !busy) req_idle++;
    if (mem_req && mem_ready && lcnt < 16) begin
      l_addr[lcnt] = mem_addr; l_we[lcnt] = mem_we; l_wdata[lcnt] = mem_wdata;
      l_wb[lcnt] = wb_en; l_wbi[lcnt] = wb_idx; l_wbd[lcnt] = wb_data;
      l_pc[lcnt] = pc_we ? (pc_data == mem_rdata) : 1'b0; l_fl[lcnt] = flush;
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
      if (wb_en) regs[wb_idx] = wb_data;
      lcnt++;
    end
    if (done) begin
      dcnt++; d_bwe = base_we; d_bout = base_out; d_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic init_state();
    for (int i = 0; i < 8; i++) regs[i] = 32'h51500000 + 32'(i * 17);
    for (int i = 0; i < 256; i++) mem[i] = 32'h70000000 + 32'(i * 32'h00010003);
  endtask

  // Runs one operation from a negedge+1 point and checks all results.
  task automatic run_op(input logic [1:0] o, input logic [7:0] lst, input logic x,
                        input logic [31:0] b, input logic [2:0] bi, input bit intrude,
                        input string req);
    logic [31:0] e_addr [0:15], e_wd [0:15], e_wbd [0:15];
    logic e_we [0:15], e_wb [0:15], e_pc [0:15];
    logic [2:0] e_wbi [0:15];
    int n = 0, wait_n = 0, scyc, lsnap;
    logic [31:0] a = b;
    logic e_bwe;
    bit empty;
    empty = (lst == 0) && !(x && !o[1]);
    if (o == 2'b00) begin
      if (x) begin
        a -= 4; e_addr[n] = a; e_we[n] = 1; e_wd[n] = lr_in; e_wb[n] = 0; e_pc[n] = 0; n++;
      end
      for (int i = 7; i >= 0; i--) if (lst[i]) begin
        a -= 4; e_addr[n] = a; e_we[n] = 1; e_wd[n] = regs[i]; e_wb[n] = 0; e_pc[n] = 0; n++;
      end
    end else begin
      for (int i = 0; i < 8; i++) if (lst[i]) begin
        e_addr[n] = a; e_we[n] = (o == 2'b10); e_wd[n] = regs[i];
        e_wb[n] = (o != 2'b10); e_wbi[n] = 3'(i); e_wbd[n] = mem[a[9:2]]; e_pc[n] = 0;
        a += 4; n++;
      end
      if (o == 2'b01 && x) begin
        e_addr[n] = a; e_we[n] = 0; e_wb[n] = 0; e_pc[n] = 1; a += 4; n++;
      end
    end
    e_bwe = !(o == 2'b11 && lst[bi]);
    lcnt = 0; dcnt = 0;
    op = o; rlist = lst; extra = x; base_in = b; base_idx = bi; start = 1'b1;
    scyc = cyc;
    @(negedge clk); #1;
    if (intrude) begin
      op = 2'b01; rlist = 8'hFF; extra = 1'b1; base_in = 32'h100;
      @(negedge clk); #1;
    end
    start = 1'b0;
    while (dcnt == 0 && wait_n < 200) begin @(negedge clk); #1; wait_n++; end
    chk(dcnt == 1, req, "done count", dcnt, 1);
    chk(lcnt == n, req, "transfer count", lcnt, n);
    for (int k = 0; k < n && k < lcnt; k++) begin
      chk({l_addr[k][31:2], 2'b00} == {e_addr[k][31:2], 2'b00} && l_addr[k][1:0] == 2'b00,
          req, "address (R8)", l_addr[k], {e_addr[k][31:2], 2'b00});
      chk(l_we[k] == e_we[k], req, "direction", 32'(l_we[k]), 32'(e_we[k]));
      if (e_we[k]) chk(l_wdata[k] == e_wd[k], req, "store data", l_wdata[k], e_wd[k]);
      chk(l_wb[k] == e_wb[k], req, "write-back strobe", 32'(l_wb[k]), 32'(e_wb[k]));
      if (e_wb[k]) begin
        chk(l_wbi[k] == e_wbi[k], req, "write-back index", 32'(l_wbi[k]), 32'(e_wbi[k]));
        chk(l_wbd[k] == e_wbd[k], req, "write-back data", l_wbd[k], e_wbd[k]);
      end
      chk(l_pc[k] == e_pc[k] && l_fl[k] == e_pc[k], "R5", "pc write with flush",
          {l_pc[k], l_fl[k]}, {e_pc[k], e_pc[k]});
    end
    chk(d_bwe == e_bwe, "R11", "base write strobe", 32'(d_bwe), 32'(e_bwe));
    chk(d_bout == a, "R9", "final base", d_bout, a);
    if (empty) chk(d_cyc == scyc + 1, "R7", "empty completion cycle", d_cyc, scyc + 1);
    if (intrude) begin
      lsnap = lcnt;
      repeat (4) @(negedge clk);
      #1;
      chk(lcnt == lsnap && dcnt == 1 && !busy, "R10", "start during busy ignored",
          lcnt, lsnap);
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic t_reset();
    @(negedge clk); #1;
    chk(!mem_req && !busy && !done && !base_we && !wb_en && !pc_we && !flush, "R1",
        "idle outputs after reset",
        {mem_req, busy, done, base_we, wb_en, pc_we, flush}, 0);
  endtask

  task automatic t_push();   run_op(2'b00, 8'b1001_0010, 1'b1, 32'h200, 3'd0, 0, "R2 R3"); endtask
  task automatic t_push_nl();run_op(2'b00, 8'b0000_0101, 1'b0, 32'h180, 3'd0, 0, "R3");    endtask
  task automatic t_pop_slow();
    slow = 1'b1;
    run_op(2'b01, 8'b0010_0101, 1'b1, 32'h1E0, 3'd0, 0, "R4 R5 R12");
    slow = 1'b0;
    chk(hold_err == 0, "R12", "request held while not ready", hold_err, 0);
  endtask
  task automatic t_stm();    run_op(2'b10, 8'b0000_1101, 1'b1, 32'h43, 3'd2, 0, "R6 R8"); endtask
  task automatic t_ldm_keep();run_op(2'b11, 8'b0100_0010, 1'b0, 32'h80, 3'd1, 0, "R6 R11"); endtask
  task automatic t_ldm_wb(); run_op(2'b11, 8'b0000_1000, 1'b0, 32'h90, 3'd0, 0, "R6 R9"); endtask
  task automatic t_empty();
    run_op(2'b00, 8'h00, 1'b0, 32'h300, 3'd0, 0, "R7");
    run_op(2'b10, 8'h00, 1'b1, 32'h304, 3'd0, 0, "R6 R7");
    run_op(2'b01, 8'h00, 1'b1, 32'h308, 3'd0, 0, "R5");
    chk(req_idle == 0, "R7", "no request while idle", req_idle, 0);
  endtask
  task automatic t_busy();   run_op(2'b00, 8'b1100_0000, 1'b0, 32'h240, 3'd0, 1, "R10"); endtask
  task automatic t_full_slow();
    slow = 1'b1;
    run_op(2'b00, 8'hFF, 1'b1, 32'h3F0, 3'd0, 0, "R3 R12");
    run_op(2'b01, 8'hFF, 1'b1, 32'h3CC, 3'd0, 0, "R4 R5");
    slow = 1'b0;
    chk(hold_err == 0, "R12", "request held while not ready", hold_err, 0);
  endtask

  initial begin
    init_state();
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_push();
    t_push_nl();
    t_pop_slow();
    t_stm();
    t_ldm_keep();
    t_ldm_wb();
    t_empty();
    t_busy();
    t_full_slow();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule